// File: doc/BRIEF.md
# Stereo Digital Volume and Soft-Mute Stage

This block scales a stream of stereo PCM sample pairs on their way to an output converter. Each channel has its own 6-bit attenuation code. The code sets the attenuation in whole decibels from 0 dB, which is unity gain and the largest gain the block offers, down to 60 dB. Any code above that silences the channel. A routing control can exchange the two channels before scaling. A soft-mute request fades both channels out one decibel per sample pair instead of cutting them off at once, and fades them back in the same way when it is withdrawn.

Sample pairs enter and leave through a valid/ready handshake. Stalls at the output propagate back to the input. The attenuation, routing and mute controls are static register values. They are sampled when a pair is accepted, and they stay bound to that pair through the two-stage pipeline. Each gain comes from a coefficient table that is computed when the design is elaborated. The sample is multiplied by that coefficient, rounded and saturated back to the sample width.

Top module: `stereo_vol_stage`

## Requirements
- R1: A code n from 0 to 60 scales the sample by a 16-bit coefficient with 15 fraction bits equal to round(32768·10^(-n/20)), give or take a few LSBs. Code 0 passes the sample through unchanged.
- R2: An effective attenuation code of 61, 62 or 63 drives that output channel to exactly zero.
- R3: `vol_left` acts only on `out_left` and `vol_right` acts only on `out_right`. The two settings are independent.
- R4: With `swap_lr` = 0, each output carries the input of the same side. With `swap_lr` = 1, `out_left` carries `in_right` and `out_right` carries `in_left`. Volume is applied after routing, by output side.
- R5: While `soft_mute` = 1, the effective attenuation of a channel grows by one code per accepted pair, starting at code+1 on the first pair. It stops once it reaches 61 (silence), and the output then stays zero.
- R6: After `soft_mute` returns to 0, the added attenuation shrinks by one code per accepted pair until the programmed code is reached again.
- R7: The volume, routing and mute controls are sampled at the cycle a pair is accepted (`in_valid` and `in_ready` both high). Both channels of a pair use that single snapshot.
- R8: The scaled result is rounded to the nearest integer and saturated to the 24-bit signed range. A full-scale negative sample at code 0 comes out as -8388608.
- R9: Pairs leave in the order they entered, with none lost or repeated. While `out_valid` = 1 and `out_ready` = 0, the outputs hold steady.
- R10: During and just after reset, `out_valid` = 0, `in_ready` = 1 and no fade is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Block can accept an input pair |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| vol_left | input | 6 | Left output attenuation code in dB (61..63 = silent) |
| vol_right | input | 6 | Right output attenuation code in dB (61..63 = silent) |
| soft_mute | input | 1 | Request a fade to silence |
| swap_lr | input | 1 | Exchange left and right before scaling |
| out_valid | output | 1 | Output pair present |
| out_ready | input | 1 | Consumer takes the output pair |
| out_left | output | 24 | Left output sample |
| out_right | output | 24 | Right output sample |

## Verification
The fade step of the soft-mute ramp and a change of a channel's volume code can land on the same accepted pair. In that case the new code and the new ramp offset must add into one effective attenuation for that pair. The bench provokes this by rewriting both volume codes before every pair of a fade-out and a fade-in, with routing exchanged in part of the run and output stalls applied at random. Each output pair is judged against a model that advances its own ramp per channel at acceptance and recomputes the expected gain in floating point.

// File: rtl/svol_pkg.sv
// svol_pkg: shared constants and the elaboration-time gain computation for
// the stereo volume stage. Assumes coefficients carry COEF_W-1 fraction bits.
package svol_pkg;

    // Step factor 10^(-1/20) held in 30 fraction bits.
    localparam longint STEP_Q30 = 64'd956973409;
    localparam int     ACC_FRAC = 30;

    // Gain for an attenuation of n dB, as an unsigned fraction with
    // coef_w-1 fraction bits, built by repeated multiplication.
    function automatic longint db_coef(input int n, input int coef_w);
        longint acc;
        int     sh;
        acc = longint'(1) <<< ACC_FRAC;
        for (int i = 0; i < n; i++) begin
            acc = (acc * STEP_Q30 + (longint'(1) <<< (ACC_FRAC - 1))) >>> ACC_FRAC;
        end
        sh = ACC_FRAC - (coef_w - 1);
        return (acc + (longint'(1) <<< (sh - 1))) >>> sh;
    endfunction

endpackage

// File: rtl/svol_coef_rom.sv
// svol_coef_rom: maps an attenuation code to a gain coefficient.
// Codes above MAX_ATT give a zero coefficient. The table is derived at
// elaboration; no stored contents.
module svol_coef_rom #(
    parameter int CODE_W  = 6,
    parameter int COEF_W  = 16,
    parameter int MAX_ATT = 60
) (
    input  logic [CODE_W-1:0] att,
    output logic [COEF_W-1:0] coef
);

    logic [COEF_W-1:0] table_q [MAX_ATT+1];

    // One constant entry per supported attenuation step.
    for (genvar g = 0; g <= MAX_ATT; g++) begin : g_entry
        assign table_q[g] = COEF_W'(svol_pkg::db_coef(g, COEF_W));
    end

    // Select the entry matching the code; out-of-range codes fall to zero.
    always_comb begin
        coef = '0;
        for (int i = 0; i <= MAX_ATT; i++) begin
            if (att == CODE_W'(i)) coef = table_q[i];
        end
    end

endmodule

// File: rtl/svol_ramp.sv
// svol_ramp: per-channel soft-mute fader. Keeps an extra attenuation offset
// that moves one step per accepted pair toward silence or back to zero, and
// outputs the effective code for the pair being accepted.
// Assumes step is high only in the cycle a pair is accepted.
module svol_ramp #(
    parameter int CODE_W  = 6,
    parameter int MAX_ATT = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              mute_req,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] att
);

    localparam int SUM_W    = CODE_W + 1;
    localparam int MUTE_ATT = MAX_ATT + 1;

    logic [CODE_W-1:0] ramp, ramp_nxt;
    logic [SUM_W-1:0]  sum_now, sum_nxt;
    logic              silent_now;

    // Decide the next ramp offset from the request and the current depth.
    always_comb begin
        sum_now    = {1'b0, code} + {1'b0, ramp};
        silent_now = (sum_now >= SUM_W'(MUTE_ATT));
        if (mute_req)
            ramp_nxt = silent_now ? ramp : ramp + 1'b1;
        else
            ramp_nxt = (ramp != '0) ? ramp - 1'b1 : ramp;
        sum_nxt = {1'b0, code} + {1'b0, ramp_nxt};
        att     = (sum_nxt >= SUM_W'(MUTE_ATT)) ? CODE_W'(MUTE_ATT) : sum_nxt[CODE_W-1:0];
    end

    // Commit the offset when a pair is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ramp <= '0;
        else if (step)
            ramp <= ramp_nxt;
    end

    // R5/R6: the offset moves by at most one step per accepted pair.
    p_ramp_unit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (ramp == $past(ramp)) || (ramp == $past(ramp) + 1'b1) ||
                 (ramp + 1'b1 == $past(ramp)));

    // R6: without an accepted pair the offset does not move.
    p_ramp_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(ramp));

    // R6: a withdrawn request never deepens the fade.
    p_ramp_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !mute_req) |=> (ramp <= $past(ramp)));

endmodule

// File: rtl/svol_scale.sv
// svol_scale: multiplies one signed sample by the gain for its code, then
// rounds and saturates back to SAMPLE_W bits. Purely combinational.
// Assumes coefficients never exceed unity (1 << (COEF_W-1)).
module svol_scale #(
    parameter int SAMPLE_W = 24,
    parameter int COEF_W   = 16,
    parameter int CODE_W   = 6,
    parameter int MAX_ATT  = 60
) (
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic        [CODE_W-1:0]   att,
    output logic signed [SAMPLE_W-1:0] result
);

    localparam int FRAC   = COEF_W - 1;
    localparam int PROD_W = SAMPLE_W + COEF_W + 1;
    localparam logic signed [PROD_W-1:0] HI = (PROD_W'(1) <<< (SAMPLE_W - 1)) - 1;
    localparam logic signed [PROD_W-1:0] LO = -HI - 1;
    localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (FRAC - 1);

    logic        [COEF_W-1:0] coef;
    logic signed [PROD_W-1:0] prod, shifted;

    svol_coef_rom #(.CODE_W(CODE_W), .COEF_W(COEF_W), .MAX_ATT(MAX_ATT)) u_rom (
        .att  (att),
        .coef (coef)
    );

    // Multiply, round half up, then clamp into the sample range.
    always_comb begin
        prod    = $signed(sample) * $signed({1'b0, coef});
        shifted = (prod + HALF) >>> FRAC;
        if (att > CODE_W'(MAX_ATT))
            result = '0;
        else if (shifted > HI)
            result = HI[SAMPLE_W-1:0];
        else if (shifted < LO)
            result = LO[SAMPLE_W-1:0];
        else
            result = shifted[SAMPLE_W-1:0];
    end

endmodule

// File: rtl/stereo_vol_stage.sv
// stereo_vol_stage: stereo volume, soft mute and channel exchange.
// Stage A captures the routed pair with the effective code of each channel.
// Stage B holds the scaled pair for the consumer. Both stages use a
// valid/ready handshake with back-pressure. Channel index 0 is left, 1 is right.
// Assumes the controls are register outputs, stable around each acceptance.
module stereo_vol_stage #(
    parameter int SAMPLE_W = 24,
    parameter int COEF_W   = 16,
    parameter int CODE_W   = 6,
    parameter int MAX_ATT  = 60
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic [CODE_W-1:0]   vol_left,
    input  logic [CODE_W-1:0]   vol_right,
    input  logic                soft_mute,
    input  logic                swap_lr,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right
);

    localparam int NCH      = 2;
    localparam int MUTE_ATT = MAX_ATT + 1;

    logic                in_fire, a_valid, a_ready, a_fire;
    logic [SAMPLE_W-1:0] routed [NCH];
    logic [CODE_W-1:0]   code   [NCH];
    logic [CODE_W-1:0]   att    [NCH];
    logic [SAMPLE_W-1:0] a_smp  [NCH];
    logic [CODE_W-1:0]   a_att  [NCH];
    logic [SAMPLE_W-1:0] scaled [NCH];
    logic [SAMPLE_W-1:0] b_smp  [NCH];

    // Handshake: each stage advances when its successor has room.
    always_comb begin
        a_ready  = !out_valid || out_ready;
        a_fire   = a_valid && a_ready;
        in_ready = !a_valid || a_ready;
        in_fire  = in_valid && in_ready;
    end

    // Route inputs by the exchange control and pick codes by output side.
    always_comb begin
        routed[0] = swap_lr ? in_right : in_left;
        routed[1] = swap_lr ? in_left  : in_right;
        code[0]   = vol_left;
        code[1]   = vol_right;
    end

    // Per-channel fader and multiplier.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        svol_ramp #(.CODE_W(CODE_W), .MAX_ATT(MAX_ATT)) u_ramp (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (in_fire),
            .mute_req (soft_mute),
            .code     (code[ch]),
            .att      (att[ch])
        );

        svol_scale #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .CODE_W(CODE_W),
                     .MAX_ATT(MAX_ATT)) u_scale (
            .sample (a_smp[ch]),
            .att    (a_att[ch]),
            .result (scaled[ch])
        );

        // Stage A data: routed sample and its effective code.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_smp[ch] <= '0;
                a_att[ch] <= '0;
            end else if (in_fire) begin
                a_smp[ch] <= routed[ch];
                a_att[ch] <= att[ch];
            end
        end

        // Stage B data: scaled sample held until taken.
        always_ff @(posedge clk) begin
            if (!rst_n)
                b_smp[ch] <= '0;
            else if (a_fire)
                b_smp[ch] <= scaled[ch];
        end
    end

    // Stage valid flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_valid   <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            if (in_ready) a_valid   <= in_valid;
            if (a_ready)  out_valid <= a_valid;
        end
    end

    // Drive the output ports from stage B.
    always_comb begin
        out_left  = b_smp[0];
        out_right = b_smp[1];
    end

    // R1: a zero code passes the staged sample through unchanged.
    p_unity_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (a_fire && a_att[0] == '0) |=> (out_left == $past(a_smp[0])));

    // R2: a silent code on the right channel produces zero.
    p_hard_mute_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (a_fire && a_att[1] == CODE_W'(MUTE_ATT)) |=> (out_right == '0));

    // R9: a stalled output pair holds its value.
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right)));

    // R10: reset leaves the pipeline empty.
    p_reset_empty_r10: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !a_valid));

endmodule

// File: tb/tb_stereo_vol_stage.sv
// Scoreboard bench: the driver pushes expected pairs at acceptance and the
// monitor compares them with each output transfer.
module tb_stereo_vol_stage;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_left = '0, in_right = '0;
    logic [5:0]  vol_left = '0, vol_right = '0;
    logic        soft_mute = 1'b0, swap_lr = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [23:0] out_left, out_right;

    int    errors = 0, checks = 0;
    int    pushed = 0, popped = 0;
    bit    stall_en = 1'b0;
    bit    done = 1'b0;
    int    ramp_m [2] = '{0, 0};
    int    q_l[$], q_r[$], q_tl[$], q_tr[$];
    string q_tag[$];

    always #4 clk = ~clk;

    stereo_vol_stage dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_left(in_left), .in_right(in_right), .vol_left(vol_left),
        .vol_right(vol_right), .soft_mute(soft_mute), .swap_lr(swap_lr),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_left(out_left), .out_right(out_right)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_val(input int x, input int a);
        real p;
        int  e;
        if (a >= 61) return 0;
        p = x * (10.0 ** (-a / 20.0));
        e = $rtoi($floor(p + 0.5));
        if (e > 8388607) e = 8388607;
        if (e < -8388608) e = -8388608;
        return e;
    endfunction

    function automatic int tol_for(input int x, input int a);
        if (a == 0 || a >= 61) return 0;
        return 2 + ((x < 0 ? -x : x) / 8192);
    endfunction

    // Reference fader for one channel: advance and return the effective code.
    function automatic int model_att(input int ch, input int code, input bit m);
        int s;
        if (m) begin
            if (code + ramp_m[ch] < 61) ramp_m[ch]++;
        end else if (ramp_m[ch] > 0) begin
            ramp_m[ch]--;
        end
        s = code + ramp_m[ch];
        return (s > 61) ? 61 : s;
    endfunction

    // Driver: offer one pair, record the expectation at acceptance.
    task automatic send(input int l, input int r, input string tag);
        int sl, sr, al, ar;
        in_left  = l[23:0];
        in_right = r[23:0];
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        sl = swap_lr ? r : l;
        sr = swap_lr ? l : r;
        al = model_att(0, int'(vol_left), soft_mute);
        ar = model_att(1, int'(vol_right), soft_mute);
        q_l.push_back(exp_val(sl, al));
        q_r.push_back(exp_val(sr, ar));
        q_tl.push_back(tol_for(sl, al));
        q_tr.push_back(tol_for(sr, ar));
        q_tag.push_back(tag);
        pushed++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compare every transferred pair with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (q_l.size() == 0) begin
                check(1'b0, "R9 unexpected pair", $signed(out_left), 0);
            end else begin
                int el, er, tl, tr, gl, gr;
                string tg;
                el = q_l.pop_front(); er = q_r.pop_front();
                tl = q_tl.pop_front(); tr = q_tr.pop_front();
                tg = q_tag.pop_front();
                gl = $signed(out_left); gr = $signed(out_right);
                popped++;
                check((gl - el <= tl) && (el - gl <= tl), {tg, " left"}, gl, el);
                check((gr - er <= tr) && (er - gr <= tr), {tg, " right"}, gr, er);
            end
        end
    end

    // Consumer back-pressure pattern.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            out_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R10 out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);

        // R1 and R8: unity gain, including the full-scale extremes.
        send(8388607, -8388608, "R8 full scale unity");
        send(-8388608, 8388607, "R8 full scale unity swapped sides");
        send(12345, -54321, "R1 unity");

        // R1 and R2: sweep the left code through every value.
        vol_right = 6'd3;
        for (int n = 0; n < 64; n++) begin
            vol_left = n[5:0];
            send(4000000, -3000000, n > 60 ? "R2 silent code" : "R1 code sweep");
        end

        // R3: independent settings on each side.
        vol_left = 6'd6; vol_right = 6'd20;
        send(1000000, 1000000, "R3 independent");
        vol_left = 6'd62; vol_right = 6'd0;
        send(-777777, -777777, "R3 one side silent");

        // R4: channel exchange with unequal volumes.
        swap_lr = 1'b1; vol_left = 6'd0; vol_right = 6'd12;
        send(111111, -2222222, "R4 exchange");
        send(-5000000, 42, "R4 exchange");
        swap_lr = 1'b0;
        send(111111, -2222222, "R4 straight");

        // R9: random stalls while streaming.
        stall_en = 1'b1;
        vol_left = 6'd1; vol_right = 6'd2;
        for (int k = 0; k < 40; k++) send(k * 150001 - 3000000, 2000000 - k * 99999, "R9 stalled stream");

        // R5/R7: fade-out while codes change every pair, part of it exchanged.
        soft_mute = 1'b1;
        for (int k = 0; k < 70; k++) begin
            vol_left  = 6'((k * 7) % 40);
            vol_right = 6'((k * 3) % 25);
            swap_lr   = (k % 20) < 10;
            send(6000000 - k * 1000, -6000000 + k * 777, "R5 R7 fade out");
        end

        // R6/R7: fade-in with changing codes.
        soft_mute = 1'b0;
        for (int k = 0; k < 70; k++) begin
            vol_left  = 6'((k * 5) % 30);
            vol_right = 6'((k * 11) % 45);
            swap_lr   = (k % 14) < 7;
            send(-4000000 + k * 3333, 5000000 - k * 4444, "R6 R7 fade in");
        end

        // R6: settled again, codes back to unity.
        swap_lr = 1'b0; vol_left = 6'd0; vol_right = 6'd0;
        send(300, -300, "R6 recovered unity");

        // R9: drain and confirm every pair came out once.
        stall_en = 1'b0;
        for (int w = 0; w < 200 && q_l.size() != 0; w++) @(negedge clk);
        repeat (4) @(negedge clk);
        check(popped == pushed, "R9 pair count", popped, pushed);
        check(out_valid == 1'b0, "R9 no extra pair", out_valid, 0);
        finish_run();
    end

endmodule